// File: doc/BRIEF.md
# Strobed Port Handshake Flag Controller

This block keeps the handshake state for two 8-bit parallel ports. The state is a buffer-full flag for each port and direction, plus four interrupt-enable bits. Either port can run in a strobed mode. In that mode, a write by the host marks the output buffer full, and the peripheral empties it by pulling an acknowledge line low. For input, the peripheral pulls a strobe line low to mark the input buffer full. Port A also has a bidirectional mode, in which both of its flags are live at once.

The peripheral-side strobe and acknowledge lines arrive as an 8-bit control-port value. The block samples that value on every rising clock edge. The current group modes and port directions come from a mode register held outside the block. The block receives them as levels, along with a one-cycle pulse that marks a fresh mode write. Single-bit set/reset commands give a bit index and a value, and they load the interrupt enables. When a flag changes because of a control-port line, the block raises a one-cycle request so that the control-port output can be redrawn.

Top module: `hs_flag_ctrl`

## Requirements
- R1: While reset is held, every flag output and `ctl_refresh` read 0.
- R2: When `mode_set` is high, every buffer flag and every interrupt enable reads 0 after the clock edge. This takes priority over any write, command or line event in the same cycle.
- R3: A data write sets the write flag after the clock edge under two conditions. For `obf_a`, port A must be an output (`a_dir`=0) and group A must not be in mode 0. For `obf_b`, port B must be an output and group B must be in mode 1. In any other setting, a write leaves the flags unchanged.
- R4: A low on `ctl_in[6]` clears a set `obf_a`. This applies when group A is in mode 1 with port A as an output, or when group A is in mode 2.
- R5: A low on `ctl_in[4]` sets a clear `ibf_a`. This applies when group A is in mode 1 with port A as an input, or when group A is in mode 2.
- R6: With group B in mode 1, a low on `ctl_in[2]` has one of two effects. If port B is an output, it clears `obf_b`. If port B is an input, it sets `ibf_b`.
- R7: In mode 0, or in the direction that does not use it, a low handshake line leaves the flags unchanged.
- R8: With group B in mode 1, a set/reset command with index 2 loads `inte_b` from `bsr_value`. In group B mode 0, such a command leaves `inte_b` unchanged.
- R9: With group A in mode 1, a command loads `inte_a` from one of two indices. Index 4 is used when port A is an input, and index 6 when port A is an output. The other index has no effect.
- R10: With group A in mode 2, a command with index 4 loads `inte_2`, and a command with index 6 loads `inte_1`.
- R11: `ctl_refresh` is high for exactly the cycle in which a flag changed by a control-port line first shows. A line held low gives one pulse only. Writes and commands never raise it.
- R12: A raw group A mode value of 3 behaves as mode 2 (bidirectional). Mode 0 is encoded 0 and mode 1 is encoded 1. The direction encoding is 1 for input and 0 for output.
- R13: If a port A write and a port A acknowledge occur in the same cycle, the write wins. `obf_a` stays set, and no refresh pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_mode_raw | input | 2 | Group A mode field: 0 basic, 1 strobed, 2 or 3 bidirectional |
| a_dir | input | 1 | Port A direction, 1 input, 0 output |
| b_mode | input | 1 | Group B mode: 0 basic, 1 strobed |
| b_dir | input | 1 | Port B direction, 1 input, 0 output |
| mode_set | input | 1 | One-cycle pulse marking a new mode word |
| data_wr_a | input | 1 | One-cycle pulse for a port A data write |
| data_wr_b | input | 1 | One-cycle pulse for a port B data write |
| bsr_valid | input | 1 | One-cycle pulse for a single-bit set/reset command |
| bsr_sel | input | 3 | Control-port bit index addressed by the command |
| bsr_value | input | 1 | Value written by the command |
| ctl_in | input | 8 | Sampled control-port lines (strobe/acknowledge, active low) |
| obf_a | output | 1 | Port A output buffer full |
| ibf_a | output | 1 | Port A input buffer full |
| obf_b | output | 1 | Port B output buffer full |
| ibf_b | output | 1 | Port B input buffer full |
| inte_a | output | 1 | Port A interrupt enable (mode 1) |
| inte_b | output | 1 | Port B interrupt enable |
| inte_1 | output | 1 | Port A output-side interrupt enable (mode 2) |
| inte_2 | output | 1 | Port A input-side interrupt enable (mode 2) |
| ctl_refresh | output | 1 | One-cycle request to refresh the control-port output |

## Verification
Every result of this block is due one register stage after its cause. A write, a command, a mode pulse or a low control line that is present at a rising edge shows on the flags just after that edge. The refresh pulse lines up with the flag it reports and is gone one edge later. The driver applies each stimulus for exactly one cycle and queues the full output vector expected after the next edge. The monitor then compares that vector one nanosecond after the edge. A line held low across several items shows the single refresh pulse.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
  typedef enum logic [1:0] {
    AM_BASIC    = 2'd0,
    AM_STROBED  = 2'd1,
    AM_BIDIR    = 2'd2
  } amode_e;

  localparam logic DIR_IN  = 1'b1;
  localparam logic DIR_OUT = 1'b0;

  // raw value 3 folds onto the bidirectional mode
  function automatic amode_e fold_amode(input logic [1:0] raw);
    case (raw)
      2'd0:    return AM_BASIC;
      2'd1:    return AM_STROBED;
      default: return AM_BIDIR;
    endcase
  endfunction
endpackage

// File: rtl/hsf_port_a.sv
module hsf_port_a
  import hsf_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  amode_e mode,
  input  logic   dir,
  input  logic   wr,
  input  logic   ack_n,
  input  logic   stb_n,
  output logic   obf,
  output logic   ibf,
  output logic   evt
);
  logic out_hs, in_hs, wr_set, ack_clr, stb_set;
  logic obf_nxt, ibf_nxt, flag_en;

  always_comb begin
    out_hs  = ((mode == AM_STROBED) && (dir == DIR_OUT)) || (mode == AM_BIDIR);
    in_hs   = ((mode == AM_STROBED) && (dir == DIR_IN))  || (mode == AM_BIDIR);
    wr_set  = wr && (dir == DIR_OUT) && (mode != AM_BASIC);
    ack_clr = out_hs && obf && !ack_n && !wr_set;
    stb_set = in_hs && !ibf && !stb_n;
    flag_en = clr || wr_set || ack_clr || stb_set;
    if (clr) begin
      obf_nxt = 1'b0;
      ibf_nxt = 1'b0;
    end else begin
      obf_nxt = wr_set ? 1'b1 : (ack_clr ? 1'b0 : obf);
      ibf_nxt = stb_set ? 1'b1 : ibf;
    end
    evt = !clr && (ack_clr || stb_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obf <= 1'b0;
      ibf <= 1'b0;
    end else if (flag_en) begin
      obf <= obf_nxt;
      ibf <= ibf_nxt;
    end
  end
endmodule

// File: rtl/hsf_port_b.sv
module hsf_port_b
  import hsf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic strobed,
  input  logic dir,
  input  logic wr,
  input  logic hs_n,
  output logic obf,
  output logic ibf,
  output logic evt
);
  logic wr_set, ack_clr, stb_set, flag_en;
  logic obf_nxt, ibf_nxt;

  always_comb begin
    wr_set  = wr && strobed && (dir == DIR_OUT);
    ack_clr = strobed && (dir == DIR_OUT) && obf && !hs_n && !wr_set;
    stb_set = strobed && (dir == DIR_IN) && !ibf && !hs_n;
    flag_en = clr || wr_set || ack_clr || stb_set;
    if (clr) begin
      obf_nxt = 1'b0;
      ibf_nxt = 1'b0;
    end else begin
      obf_nxt = wr_set ? 1'b1 : (ack_clr ? 1'b0 : obf);
      ibf_nxt = stb_set ? 1'b1 : ibf;
    end
    evt = !clr && (ack_clr || stb_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obf <= 1'b0;
      ibf <= 1'b0;
    end else if (flag_en) begin
      obf <= obf_nxt;
      ibf <= ibf_nxt;
    end
  end
endmodule

// File: rtl/hsf_inte.sv
module hsf_inte
  import hsf_pkg::*;
#(
  parameter int SEL_W    = 3,
  parameter int A_IN_SEL = 4,
  parameter int A_OUT_SEL = 6,
  parameter int B_SEL    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  amode_e           amode,
  input  logic             a_dir,
  input  logic             b_strobed,
  input  logic             cmd_vld,
  input  logic [SEL_W-1:0] cmd_sel,
  input  logic             cmd_val,
  output logic             inte_a,
  output logic             inte_b,
  output logic             inte_1,
  output logic             inte_2
);
  localparam logic [SEL_W-1:0] SEL_AI = SEL_W'(A_IN_SEL);
  localparam logic [SEL_W-1:0] SEL_AO = SEL_W'(A_OUT_SEL);
  localparam logic [SEL_W-1:0] SEL_B  = SEL_W'(B_SEL);

  logic ld_a, ld_b, ld_1, ld_2;

  always_comb begin
    ld_b = cmd_vld && b_strobed && (cmd_sel == SEL_B);
    ld_a = cmd_vld && (amode == AM_STROBED) &&
           (((a_dir == DIR_IN)  && (cmd_sel == SEL_AI)) ||
            ((a_dir == DIR_OUT) && (cmd_sel == SEL_AO)));
    ld_2 = cmd_vld && (amode == AM_BIDIR) && (cmd_sel == SEL_AI);
    ld_1 = cmd_vld && (amode == AM_BIDIR) && (cmd_sel == SEL_AO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inte_a <= 1'b0;
      inte_b <= 1'b0;
      inte_1 <= 1'b0;
      inte_2 <= 1'b0;
    end else begin
      if (clr || ld_a) inte_a <= !clr && cmd_val;
      if (clr || ld_b) inte_b <= !clr && cmd_val;
      if (clr || ld_1) inte_1 <= !clr && cmd_val;
      if (clr || ld_2) inte_2 <= !clr && cmd_val;
    end
  end
endmodule

// File: rtl/hs_flag_ctrl.sv
module hs_flag_ctrl
  import hsf_pkg::*;
#(
  parameter int CTL_W     = 8,
  parameter int ACK_A_POS = 6,
  parameter int STB_A_POS = 4,
  parameter int HS_B_POS  = 2,
  localparam int SEL_W    = $clog2(CTL_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       a_mode_raw,
  input  logic             a_dir,
  input  logic             b_mode,
  input  logic             b_dir,
  input  logic             mode_set,
  input  logic             data_wr_a,
  input  logic             data_wr_b,
  input  logic             bsr_valid,
  input  logic [SEL_W-1:0] bsr_sel,
  input  logic             bsr_value,
  input  logic [CTL_W-1:0] ctl_in,
  output logic             obf_a,
  output logic             ibf_a,
  output logic             obf_b,
  output logic             ibf_b,
  output logic             inte_a,
  output logic             inte_b,
  output logic             inte_1,
  output logic             inte_2,
  output logic             ctl_refresh
);
  amode_e amode;
  logic   evt_a, evt_b, refresh_nxt;

  assign amode = fold_amode(a_mode_raw);

  hsf_port_a u_pa (
    .clk(clk), .rst_n(rst_n), .clr(mode_set), .mode(amode), .dir(a_dir),
    .wr(data_wr_a), .ack_n(ctl_in[ACK_A_POS]), .stb_n(ctl_in[STB_A_POS]),
    .obf(obf_a), .ibf(ibf_a), .evt(evt_a)
  );

  hsf_port_b u_pb (
    .clk(clk), .rst_n(rst_n), .clr(mode_set), .strobed(b_mode), .dir(b_dir),
    .wr(data_wr_b), .hs_n(ctl_in[HS_B_POS]),
    .obf(obf_b), .ibf(ibf_b), .evt(evt_b)
  );

  hsf_inte #(
    .SEL_W(SEL_W), .A_IN_SEL(STB_A_POS), .A_OUT_SEL(ACK_A_POS), .B_SEL(HS_B_POS)
  ) u_ie (
    .clk(clk), .rst_n(rst_n), .clr(mode_set), .amode(amode), .a_dir(a_dir),
    .b_strobed(b_mode), .cmd_vld(bsr_valid), .cmd_sel(bsr_sel),
    .cmd_val(bsr_value), .inte_a(inte_a), .inte_b(inte_b),
    .inte_1(inte_1), .inte_2(inte_2)
  );

  always_comb refresh_nxt = evt_a || evt_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_refresh <= 1'b0;
    else        ctl_refresh <= refresh_nxt;
  end
endmodule

// File: rtl/hsf_chk.sv
module hsf_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_set,
  input logic data_wr_a,
  input logic data_wr_b,
  input logic bsr_valid,
  input logic obf_a,
  input logic ibf_a,
  input logic obf_b,
  input logic ibf_b,
  input logic inte_a,
  input logic inte_b,
  input logic inte_1,
  input logic inte_2,
  input logic ctl_refresh
);
  logic [3:0] bufs, ints;
  assign bufs = {ibf_b, obf_b, ibf_a, obf_a};
  assign ints = {inte_2, inte_1, inte_b, inte_a};

  // R2
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_set |=> (bufs == 4'b0) && (ints == 4'b0));

  // R3
  obf_a_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(obf_a) |-> $past(data_wr_a));

  // R3
  obf_b_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(obf_b) |-> $past(data_wr_b));

  // R5
  ibf_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ibf_a) |-> $past(mode_set));

  // R6
  ibf_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ibf_b) |-> $past(mode_set));

  // R8
  inte_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ints) |-> $past(bsr_valid || mode_set));

  // R11
  refresh_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_refresh |-> !$stable(bufs));
endmodule

bind hs_flag_ctrl hsf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .data_wr_a(data_wr_a),
  .data_wr_b(data_wr_b), .bsr_valid(bsr_valid), .obf_a(obf_a), .ibf_a(ibf_a),
  .obf_b(obf_b), .ibf_b(ibf_b), .inte_a(inte_a), .inte_b(inte_b),
  .inte_1(inte_1), .inte_2(inte_2), .ctl_refresh(ctl_refresh)
);

// File: tb/sim_hs_flag_ctrl.sv
`timescale 1ns/1ps
module sim_hs_flag_ctrl;
  localparam logic [8:0] OA = 9'h001, IA = 9'h002, OB = 9'h004, IB = 9'h008;
  localparam logic [8:0] EA = 9'h010, EB = 9'h020, E1 = 9'h040, E2 = 9'h080;
  localparam logic [8:0] RF = 9'h100;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] a_mode_raw;
  logic       a_dir, b_mode, b_dir, mode_set, data_wr_a, data_wr_b;
  logic       bsr_valid, bsr_value;
  logic [2:0] bsr_sel;
  logic [7:0] ctl_in;
  logic       obf_a, ibf_a, obf_b, ibf_b, inte_a, inte_b, inte_1, inte_2;
  logic       ctl_refresh;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [8:0] exp;
    string      tag;
  } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  hs_flag_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .a_mode_raw(a_mode_raw), .a_dir(a_dir),
    .b_mode(b_mode), .b_dir(b_dir), .mode_set(mode_set),
    .data_wr_a(data_wr_a), .data_wr_b(data_wr_b), .bsr_valid(bsr_valid),
    .bsr_sel(bsr_sel), .bsr_value(bsr_value), .ctl_in(ctl_in),
    .obf_a(obf_a), .ibf_a(ibf_a), .obf_b(obf_b), .ibf_b(ibf_b),
    .inte_a(inte_a), .inte_b(inte_b), .inte_1(inte_1), .inte_2(inte_2),
    .ctl_refresh(ctl_refresh)
  );

  function automatic logic [8:0] observed();
    return {ctl_refresh, inte_2, inte_1, inte_b, inte_a, ibf_b, obf_b, ibf_a, obf_a};
  endfunction

  // driver: one stimulus cycle, expected vector after the next edge
  task automatic cyc(input logic [8:0] e, input string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    mode_set  = 1'b0;
    data_wr_a = 1'b0;
    data_wr_b = 1'b0;
    bsr_valid = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] am, input logic ad,
                          input logic bm, input logic bd);
    a_mode_raw = am; a_dir = ad; b_mode = bm; b_dir = bd; mode_set = 1'b1;
  endtask

  task automatic bsr(input logic [2:0] sel, input logic val);
    bsr_valid = 1'b1; bsr_sel = sel; bsr_value = val;
  endtask

  // monitor: compare one time unit after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() != 0) begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if (observed() !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%b expected=%b", it.tag, observed(), it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; a_mode_raw = 2'd0; a_dir = 1'b0; b_mode = 1'b0; b_dir = 1'b0;
    mode_set = 1'b0; data_wr_a = 1'b0; data_wr_b = 1'b0; bsr_valid = 1'b0;
    bsr_sel = 3'd0; bsr_value = 1'b0; ctl_in = 8'hFF;
    repeat (3) @(negedge clk);
    checks++;
    if (observed() !== 9'h000) begin
      fails++;
      $display("FAIL R1 actual=%b expected=%b", observed(), 9'h000);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // mode 0 everywhere: writes and lines ignored
    set_mode(2'd0, 1'b0, 1'b0, 1'b0);      cyc(9'h000, "R2 mode0 set");
    data_wr_a = 1'b1; data_wr_b = 1'b1;    cyc(9'h000, "R3 write in mode0");
    ctl_in = 8'h00;                         cyc(9'h000, "R7 lines in mode0");
    ctl_in = 8'hFF;

    // strobed outputs on both groups
    set_mode(2'd1, 1'b0, 1'b1, 1'b0);      cyc(9'h000, "R2 mode1 out");
    data_wr_a = 1'b1;                       cyc(OA, "R3 write A");
    data_wr_b = 1'b1;                       cyc(OA|OB, "R3 write B");
    bsr(3'd6, 1'b1);                        cyc(OA|OB|EA, "R9 inte_a out idx6");
    bsr(3'd4, 1'b1);                        cyc(OA|OB|EA, "R9 idx4 ignored out");
    bsr(3'd2, 1'b1);                        cyc(OA|OB|EA|EB, "R8 inte_b");
    ctl_in = 8'hEF;                         cyc(OA|OB|EA|EB, "R7 strobe A in output");
    ctl_in = 8'hBF;                         cyc(OB|EA|EB|RF, "R4 R11 ack A");
                                            cyc(OB|EA|EB, "R11 held ack single pulse");
    ctl_in = 8'hFB;                         cyc(EA|EB|RF, "R6 ack B");
    ctl_in = 8'hFF;                         cyc(EA|EB, "R11 pulse ends");
    data_wr_a = 1'b1;                       cyc(OA|EA|EB, "R3 rewrite A");
    data_wr_a = 1'b1; ctl_in = 8'hBF;       cyc(OA|EA|EB, "R13 write beats ack");
                                            cyc(EA|EB|RF, "R4 ack after collision");
    ctl_in = 8'hFF;

    // strobed inputs; mode pulse overrides a strobe
    set_mode(2'd1, 1'b1, 1'b1, 1'b1); ctl_in = 8'hEF; data_wr_a = 1'b1;
                                            cyc(9'h000, "R2 mode beats events");
                                            cyc(IA|RF, "R5 strobe A");
    ctl_in = 8'hEB;                         cyc(IA|IB|RF, "R6 strobe B");
    ctl_in = 8'hFF;
    bsr(3'd4, 1'b1);                        cyc(IA|IB|EA, "R9 inte_a in idx4");
    bsr(3'd6, 1'b1);                        cyc(IA|IB|EA, "R9 idx6 ignored in");
    data_wr_a = 1'b1;                       cyc(IA|IB|EA, "R3 write A as input");

    // raw mode 3 as bidirectional
    set_mode(2'd3, 1'b0, 1'b0, 1'b0);      cyc(9'h000, "R2 R12 mode3");
    data_wr_a = 1'b1;                       cyc(OA, "R12 write in bidir");
    bsr(3'd4, 1'b1);                        cyc(OA|E2, "R10 inte_2");
    bsr(3'd6, 1'b1);                        cyc(OA|E1|E2, "R10 inte_1");
    bsr(3'd6, 1'b0);                        cyc(OA|E2, "R10 inte_1 reset");
    ctl_in = 8'hAF;                         cyc(IA|E2|RF, "R4 R5 bidir both lines");
    ctl_in = 8'hFB;                         cyc(IA|E2, "R7 B line in mode0");
    ctl_in = 8'hFF;
    bsr(3'd2, 1'b1);                        cyc(IA|E2, "R8 idx2 ignored in B mode0");
    set_mode(2'd0, 1'b0, 1'b0, 1'b0);      cyc(9'h000, "R2 final clear");

    wait (sbq.size() == 0);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule